// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a video transmit path. Two counters track the pixel position within a line and the line position within a frame. Programmable thresholds on each counter decide where the horizontal and vertical sync pulses fall and where active video lies. Everything is set by input levels: the total line and frame lengths, the sync lengths, and a min/max pair per axis for the active region. Data-enable is high only where both axis windows are open.

During active video a source multiplexer picks the 24-bit pixel that goes out. It can pass the incoming pixel through, send a fixed colour, or send a counter that steps once per active pixel and starts again at every frame. An optional limited-range stage clamps each 8-bit colour component into the video legal band. Outside active video the pixel output is zero.

The block has two resets, a board-level one and a soft one, and is held in reset while either is low. When both are high, the internal reset is released through two synchronising flops. The raster then starts again at pixel 0 of line 0.

Top module: `vtg_top`

## Requirements
- R1: Consecutive rising edges of `hsync_o` are exactly `h_total` clock cycles apart; the pixel counter runs 0 to `h_total`-1.
- R2: `hsync_o` is high for the first `h_sync_len` pixels of every line (pixel counts 0 to `h_sync_len`-1).
- R3: Within an active line, `de_o` is high for pixel counts `h_act_lo` (inclusive) to `h_act_hi` (exclusive), so it rises `h_act_lo` cycles after `hsync_o` rises.
- R4: A frame is `v_total` lines; `vsync_o` is high for the first `v_sync_len` lines and rises on the same cycle as the `hsync_o` of line 0.
- R5: Lines `v_act_lo` (inclusive) to `v_act_hi` (exclusive) are active; `de_o` is high only where both the line and pixel windows are open.
- R6: With `src_sel`=0, `rgb_o` during active video carries `in_rgb`, delayed by one clock.
- R7: With `src_sel`=2, `rgb_o` during active video carries `fixed_rgb`; with `src_sel`=3 (reserved) it carries zero.
- R8: With `src_sel`=1, the first active pixel of each frame is 0 and each later active pixel is one greater than the one before.
- R9: With `full_range`=0, each component (bits [23:16], [15:8], [7:0]) is clamped to 0x10..0xEB; with `full_range`=1, values pass unchanged.
- R10: `rgb_o` is zero on every cycle where `de_o` is low.
- R11: While `rst_n` or `soft_rst_n` is low, all outputs are zero. On the third clock edge after `soft_rst_n` rises, `hsync_o` and `vsync_o` rise together, with the pixel pattern restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_n | input | 1 | Soft active-low reset level; block held while 0 |
| h_total | input | 16 | Pixel clocks per line |
| h_sync_len | input | 16 | Horizontal sync length in pixels |
| h_act_lo | input | 16 | First active pixel count |
| h_act_hi | input | 16 | First inactive pixel count after active region |
| v_total | input | 16 | Lines per frame |
| v_sync_len | input | 16 | Vertical sync length in lines |
| v_act_lo | input | 16 | First active line |
| v_act_hi | input | 16 | First inactive line after active region |
| src_sel | input | 2 | 0 input, 1 pattern, 2 fixed colour, 3 zero |
| full_range | input | 1 | 1 passes values, 0 clamps to limited range |
| fixed_rgb | input | 24 | Fixed colour value |
| in_rgb | input | 24 | Incoming pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| rgb_o | output | 24 | Output pixel |

## Verification
A wrong pixel counter shows up within one line: the spacing of `hsync_o` edges or the offset from `hsync_o` to `de_o` moves. A wrong line counter needs at most one frame before it appears as a changed `vsync_o` period, sync line count or number of active lines. A pattern counter that fails to restart or skips a value shows in the first active pixel of the next frame. A wrong clamp or multiplexer setting shows on the first active pixel after the select changes.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    SRC_INPUT   = 2'd0,
    SRC_PATTERN = 2'd1,
    SRC_FIXED   = 2'd2,
    SRC_NONE    = 2'd3
  } src_e;
endpackage

// File: rtl/vtg_rst_sync.sv
module vtg_rst_sync (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] total_i,
  input  logic [CW-1:0] sync_len_i,
  input  logic [CW-1:0] act_lo_i,
  input  logic [CW-1:0] act_hi_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          sync_o,
  output logic          act_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_cnt;

  assign last_cnt = total_i - 1'b1;
  assign wrap_o   = (cnt_q >= last_cnt);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (wrap_o) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign sync_o = (cnt_q < sync_len_i);
  assign act_o  = (cnt_q >= act_lo_i) && (cnt_q < act_hi_i);

  // R1 / R4: a stepped counter at its last count returns to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (step_i && wrap_o) |=> (cnt_q == '0));
endmodule

// File: rtl/vtg_pixel_src.sv
module vtg_pixel_src
  import vtg_pkg::*;
#(
  parameter  int COMP_W = 8,
  parameter  int NCOMP  = 3,
  localparam int PW     = COMP_W * NCOMP
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          full_range_i,
  input  logic          frame_start_i,
  input  logic          act_i,
  input  logic [PW-1:0] in_rgb_i,
  input  logic [PW-1:0] fixed_rgb_i,
  output logic [PW-1:0] pix_o
);
  localparam logic [COMP_W-1:0] CLAMP_LO = COMP_W'(8'h10) << (COMP_W - 8);
  localparam logic [COMP_W-1:0] CLAMP_HI = COMP_W'(8'hEB) << (COMP_W - 8);

  logic [PW-1:0] pat_q, pat_d, pat_cur;
  logic          pat_en;
  logic [PW-1:0] raw;

  assign pat_cur = frame_start_i ? '0 : pat_q;
  assign pat_en  = act_i || frame_start_i;

  always_comb begin
    pat_d = pat_cur;
    if (act_i) pat_d = pat_cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     pat_q <= '0;
    else if (pat_en) pat_q <= pat_d;
  end

  always_comb begin
    unique case (src_e'(sel_i))
      SRC_INPUT:   raw = in_rgb_i;
      SRC_PATTERN: raw = pat_cur;
      SRC_FIXED:   raw = fixed_rgb_i;
      default:     raw = '0;
    endcase
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [COMP_W-1:0] comp_in, comp_out;
    assign comp_in = raw[c*COMP_W +: COMP_W];

    always_comb begin
      comp_out = comp_in;
      if (!full_range_i) begin
        if (comp_in < CLAMP_LO)      comp_out = CLAMP_LO;
        else if (comp_in > CLAMP_HI) comp_out = CLAMP_HI;
      end
    end

    assign pix_o[c*COMP_W +: COMP_W] = comp_out;

    // R9: limited range keeps every component inside the legal band
    p_clamp_band_r9: assert property (@(posedge clk) disable iff (!rst_ni)
      !full_range_i |-> (comp_out >= CLAMP_LO && comp_out <= CLAMP_HI));
  end

  // R8: pattern source gives zero on an active frame-start pixel
  p_pat_restart_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (frame_start_i && act_i && full_range_i && sel_i == 2'd1) |-> (pix_o == '0));
endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
  parameter  int CW     = 16,
  parameter  int COMP_W = 8,
  parameter  int NCOMP  = 3,
  localparam int PW     = COMP_W * NCOMP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst_n,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] h_sync_len,
  input  logic [CW-1:0] h_act_lo,
  input  logic [CW-1:0] h_act_hi,
  input  logic [CW-1:0] v_total,
  input  logic [CW-1:0] v_sync_len,
  input  logic [CW-1:0] v_act_lo,
  input  logic [CW-1:0] v_act_hi,
  input  logic [1:0]    src_sel,
  input  logic          full_range,
  input  logic [PW-1:0] fixed_rgb,
  input  logic [PW-1:0] in_rgb,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [PW-1:0] rgb_o
);
  logic          arst_n, rst_int_n;
  logic [CW-1:0] h_cnt, v_cnt;
  logic          h_wrap, v_wrap, h_sync, v_sync, h_act, v_act;
  logic          act, frame_start;
  logic [PW-1:0] pix;
  logic          hsync_q, vsync_q, de_q;
  logic [PW-1:0] rgb_q, rgb_d;

  assign arst_n = rst_n & soft_rst_n;

  vtg_rst_sync i_rst_sync (
    .clk     (clk),
    .arst_ni (arst_n),
    .rst_no  (rst_int_n)
  );

  vtg_axis #(.CW(CW)) i_h_axis (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .step_i     (1'b1),
    .total_i    (h_total),
    .sync_len_i (h_sync_len),
    .act_lo_i   (h_act_lo),
    .act_hi_i   (h_act_hi),
    .cnt_o      (h_cnt),
    .wrap_o     (h_wrap),
    .sync_o     (h_sync),
    .act_o      (h_act)
  );

  vtg_axis #(.CW(CW)) i_v_axis (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .step_i     (h_wrap),
    .total_i    (v_total),
    .sync_len_i (v_sync_len),
    .act_lo_i   (v_act_lo),
    .act_hi_i   (v_act_hi),
    .cnt_o      (v_cnt),
    .wrap_o     (v_wrap),
    .sync_o     (v_sync),
    .act_o      (v_act)
  );

  assign act         = h_act && v_act;
  assign frame_start = (h_cnt == '0) && (v_cnt == '0);

  vtg_pixel_src #(.COMP_W(COMP_W), .NCOMP(NCOMP)) i_pix (
    .clk           (clk),
    .rst_ni        (rst_int_n),
    .sel_i         (src_sel),
    .full_range_i  (full_range),
    .frame_start_i (frame_start),
    .act_i         (act),
    .in_rgb_i      (in_rgb),
    .fixed_rgb_i   (fixed_rgb),
    .pix_o         (pix)
  );

  assign rgb_d = act ? pix : '0;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hsync_q <= 1'b0;
      vsync_q <= 1'b0;
      de_q    <= 1'b0;
      rgb_q   <= '0;
    end else begin
      hsync_q <= h_sync;
      vsync_q <= v_sync;
      de_q    <= act;
      rgb_q   <= rgb_d;
    end
  end

  assign hsync_o = hsync_q;
  assign vsync_o = vsync_q;
  assign de_o    = de_q;
  assign rgb_o   = rgb_q;

  // R10: a nonzero pixel only appears with data-enable
  p_blank_zero_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rgb_o != '0) |-> de_o);

  // R4: vertical sync starts on a line start
  p_vs_on_line_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(vsync_o) && h_sync_len != '0) |-> hsync_o);

  // R4: frame wrap happens only at the end of a line
  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (h_wrap && v_wrap) |=> frame_start);
endmodule

// File: tb/test_vtg_top.sv
module test_vtg_top;
  localparam int HT = 20, HS = 3, HLO = 6, HHI = 16;
  localparam int VT = 8, VS = 2, VLO = 3, VHI = 6;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst_n, soft_rst_n;
  logic [1:0]  src_sel;
  logic        full_range;
  logic [23:0] fixed_rgb, in_rgb;
  logic        hsync_o, vsync_o, de_o;
  logic [23:0] rgb_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  vtg_top i_vtg_top (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
    .h_total(16'(HT)), .h_sync_len(16'(HS)), .h_act_lo(16'(HLO)), .h_act_hi(16'(HHI)),
    .v_total(16'(VT)), .v_sync_len(16'(VS)), .v_act_lo(16'(VLO)), .v_act_hi(16'(VHI)),
    .src_sel(src_sel), .full_range(full_range), .fixed_rgb(fixed_rgb), .in_rgb(in_rgb),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .rgb_o(rgb_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Port monitor, sampled on falling edges
  int cyc = 0;
  int last_hs = -1, last_vs = -1;
  int hs_period = 0, hs_len_m = 0, hs_run = 0;
  int de_off = 0, de_len_m = 0, de_run = 0;
  int vs_period = 0, vs_lines = 0, vs_lines_m = 0;
  int de_lines = 0, de_lines_m = 0, fde_off = 0;
  logic hs_p = 1'b0, vs_p = 1'b0, de_p = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (hsync_o && !hs_p) begin
      if (last_hs >= 0) hs_period = cyc - last_hs;
      last_hs = cyc;
      if (vsync_o) vs_lines++;
    end
    if (vsync_o && !vs_p) begin
      if (last_vs >= 0) vs_period = cyc - last_vs;
      last_vs = cyc;
      de_lines_m = de_lines;
      de_lines = 0;
    end
    if (!vsync_o && vs_p) begin
      vs_lines_m = vs_lines;
      vs_lines = 0;
    end
    if (hsync_o) hs_run++;
    else if (hs_p) begin hs_len_m = hs_run; hs_run = 0; end
    if (de_o && !de_p) begin
      de_off = cyc - last_hs;
      if (de_lines == 0) fde_off = cyc - last_vs;
      de_lines++;
    end
    if (de_o) de_run++;
    else if (de_p) begin de_len_m = de_run; de_run = 0; end
    hs_p = hsync_o; vs_p = vsync_o; de_p = de_o;
  end

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_vs_rise();
    logic p;
    p = vsync_o;
    forever begin
      @(negedge clk);
      if (vsync_o && !p) break;
      p = vsync_o;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; soft_rst_n = 1'b0;
    src_sel = 2'd0; full_range = 1'b1; fixed_rgb = '0; in_rgb = '0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(6);
    chk("R11 reset hsync", int'(hsync_o), 0);
    chk("R11 reset vsync", int'(vsync_o), 0);
    chk("R11 reset de", int'(de_o), 0);
    chk("R11 reset rgb", int'(rgb_o), 0);
    soft_rst_n = 1'b1;
  endtask

  task automatic t_timing();
    wait_cycles(2 * FRAME + 10);
    chk("R1 line period", hs_period, HT);
    chk("R2 hsync length", hs_len_m, HS);
    chk("R3 de offset", de_off, HLO);
    chk("R3 de length", de_len_m, HHI - HLO);
    chk("R4 frame period", vs_period, FRAME);
    chk("R4 vsync lines", vs_lines_m, VS);
    chk("R5 active lines", de_lines_m, VHI - VLO);
    chk("R5 first active offset", fde_off, VLO * HT + HLO);
  endtask

  task automatic t_source(string req, logic [1:0] sel, logic fr, logic [23:0] val, logic [23:0] exp);
    int bad_act, bad_blank, n_act;
    src_sel = sel; full_range = fr; fixed_rgb = val; in_rgb = val;
    wait_vs_rise();
    bad_act = 0; bad_blank = 0; n_act = 0;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (de_o) begin
        n_act++;
        if (rgb_o != exp) begin
          bad_act++;
          $display("FAIL %s: actual=0x%0h expected=0x%0h", req, rgb_o, exp);
        end
      end else if (rgb_o != 24'h0) bad_blank++;
    end
    chk(req, bad_act, 0);
    chk("R10 zero when blank", bad_blank, 0);
    chk("R5 active pixels per frame", n_act, (HHI - HLO) * (VHI - VLO));
  endtask

  task automatic t_pattern();
    int k, bad;
    src_sel = 2'd1; full_range = 1'b1;
    for (int f = 0; f < 2; f++) begin
      wait_vs_rise();
      k = 0; bad = 0;
      for (int i = 0; i < FRAME - 1; i++) begin
        @(negedge clk);
        if (de_o) begin
          if (k == 0) chk("R8 pattern restarts at 0", int'(rgb_o), 0);
          if (int'(rgb_o) != k) bad++;
          k++;
        end
      end
      chk("R8 pattern steps by one", bad, 0);
      chk("R8 pattern count", k, (HHI - HLO) * (VHI - VLO));
    end
  endtask

  task automatic t_soft_reset();
    int seen;
    src_sel = 2'd2; full_range = 1'b1; fixed_rgb = 24'h445566;
    wait_cycles(FRAME / 2 + 7);
    soft_rst_n = 1'b0;
    @(negedge clk);
    chk("R11 soft reset clears hsync", int'(hsync_o), 0);
    chk("R11 soft reset clears vsync", int'(vsync_o), 0);
    chk("R11 soft reset clears rgb", int'(rgb_o), 0);
    wait_cycles(4);
    soft_rst_n = 1'b1;
    seen = 0;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      if (hsync_o && seen == 0) seen = i;
    end
    chk("R11 restart latency", seen, 3);
    chk("R11 vsync with first hsync", int'(vsync_o), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_timing();
        t_source("R6 input pass", 2'd0, 1'b1, 24'h123456, 24'h123456);
        t_source("R7 fixed colour", 2'd2, 1'b1, 24'h0AC0F5, 24'h0AC0F5);
        t_source("R9 clamp", 2'd2, 1'b0, 24'h0AC0F5, 24'h10C0EB);
        t_source("R9 clamp input", 2'd0, 1'b0, 24'hFF0511, 24'hEB1011);
        t_source("R7 reserved select", 2'd3, 1'b1, 24'h777777, 24'h000000);
        t_pattern();
        t_soft_reset();
      end
      begin
        wait_cycles(20000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule